// File: doc/BRIEF.md
# DS3/E3 Transmit Maintenance Signal Generator

This block produces the serial transmit bit stream of a DS3/E3 framer, one bit per clock. In DS3 mode it tracks the position inside the 4760-bit M-frame, inserts the overhead bits and computes the parity bits. The payload comes from the line data, an alarm indication pattern or an idle pattern. In E3 mode it writes the alignment word, the remote alarm bit and the national bit into each 1536-bit frame. For the alarm indication signal it replaces the whole stream with all ones.

Alarm, remote alarm, idle, mode and national-bit source are plain level controls. They are sampled once per frame, on the first bit, so a frame never mixes two configurations. The single-bit inputs from the link-channel and loopback-code controllers, and the C-bit source, are taken live in the cycle in which their slot is generated. Both outputs are registered.

Top module: `ds3e3_maint_gen`

## Requirements
- R1: A DS3 frame is 4760 bits: 7 subframes of 8 blocks, each block being one overhead bit followed by 84 information bits. Within a subframe the overhead order is lead, F=1, C, F=0, C, F=0, C, F=1. The lead bit is X in subframes 1–2, P in subframes 3–4 and M in subframes 5–7, with M values 0,1,0. `frame_start_o` is high with the first bit of every frame.
- R2: Both P bits of a DS3 frame equal the XOR of all 4704 information bits as transmitted in the previous DS3 frame. The value is 0 in the first frame after reset or after an E3 frame.
- R3: In normal DS3 operation the information bits are `data_i` and the C bits are `c_bit_i`. Both X bits are 0 when `rai_i` is 1 and 1 when it is 0.
- R4: With `ais_i` in DS3, the information bits are 1,0,1,0,… This pattern starts at 1 on the first information bit of the frame and counts only information bits. Both X bits are 1, every C bit is 0, and F, M and P stay as in R1/R2.
- R5: With `idle_i` in DS3, the information bits are 1,1,0,0,…, counted the same way. Both X bits are 1 and the three C bits of subframe 3 are 0. The C bits of the other subframes keep `c_bit_i`, which carries the link and loopback-code channels.
- R6: AIS wins over idle and idle wins over normal data. `rai_i` affects only the X bits of normal frames.
- R7: An E3 frame is 1536 bits. Bits 1–10 carry 1111010000, sent left to right. Bit 11 carries `rai_i`, bit 12 carries the national bit, and the rest carry `data_i`. `frame_start_o` marks bit 1.
- R8: `sn_sel_i` picks the national bit: 0 forces 1, 1 takes `hdlc_bit_i`, 2 takes `feac_bit_i`, 3 forces 0.
- R9: With `ais_i` in E3 every bit is 1 and frame timing keeps running. `idle_i` has no effect in E3.
- R10: `e3_mode_i`, `ais_i`, `rai_i`, `idle_i` and `sn_sel_i` are sampled in the cycle that generates the first bit of a frame and hold for that whole frame. A mode change alters the length of the next frame only.
- R11: A bit appears on `tx_bit_o` one cycle after the cycle whose inputs produced it. During reset both outputs are 0. The first bit after reset is the first bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| e3_mode_i | input | 1 | 1 selects E3 framing, 0 selects DS3 |
| ais_i | input | 1 | Send alarm indication signal |
| rai_i | input | 1 | Send remote alarm indication |
| idle_i | input | 1 | Send DS3 idle signal |
| sn_sel_i | input | 2 | E3 national bit source select |
| data_i | input | 1 | Normal payload bit |
| c_bit_i | input | 1 | Normal DS3 C-bit value |
| hdlc_bit_i | input | 1 | National bit from link-channel controller |
| feac_bit_i | input | 1 | National bit from loopback-code controller |
| tx_bit_o | output | 1 | Transmit bit stream |
| frame_start_o | output | 1 | High with the first bit of each frame |

## Verification
Several rules are checked by assertions on every clock. These are the frame period (4760 or 1536 cycles between frame marks), the F and middle M values, zero C bits under DS3 AIS, all ones under E3 AIS, the leading ones of the E3 alignment word, and the one-cycle alignment of the frame mark. Other rules depend on history across frames or on priorities between controls, and only the bench scenarios show them. These are parity carried from the previous frame, pattern phase across overhead gaps, idle C-bit handling per subframe, the national-bit selector values, and controls that change in the middle of a frame. A mid-frame reset is also exercised by the scenarios.

// File: rtl/tx_maint_pkg.sv
package tx_maint_pkg;

  localparam int unsigned DS3_SUBFRAMES = 7;
  localparam int unsigned DS3_BLOCKS    = 8;

  typedef struct packed {
    logic       e3;
    logic       ais;
    logic       rai;
    logic       idle;
    logic [1:0] sn_sel;
  } tx_cfg_t;

  typedef enum logic [2:0] {
    SLOT_INFO,
    SLOT_X,
    SLOT_P,
    SLOT_M,
    SLOT_F1,
    SLOT_F0,
    SLOT_C
  } ds3_slot_e;

  localparam logic [1:0] SN_ONE  = 2'b00;
  localparam logic [1:0] SN_HDLC = 2'b01;
  localparam logic [1:0] SN_FEAC = 2'b10;
  localparam logic [1:0] SN_ZERO = 2'b11;

endpackage

// File: rtl/ds3e3_frame_ctr.sv
module ds3e3_frame_ctr
  import tx_maint_pkg::*;
#(
  parameter int unsigned INFO_BITS = 84,
  parameter int unsigned E3_BITS   = 1536,
  localparam int unsigned BIT_W = $clog2(INFO_BITS + 1),
  localparam int unsigned BLK_W = $clog2(DS3_BLOCKS),
  localparam int unsigned SF_W  = $clog2(DS3_SUBFRAMES),
  localparam int unsigned POS_W = $clog2(E3_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             e3_i,
  output logic             start_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [SF_W-1:0]  sf_o,
  output logic [POS_W-1:0] pos_o
);

  logic [BIT_W-1:0] bit_q;
  logic [BLK_W-1:0] blk_q;
  logic [SF_W-1:0]  sf_q;
  logic [POS_W-1:0] pos_q;
  logic             ds3_last, e3_last, last;

  assign ds3_last = (sf_q == SF_W'(DS3_SUBFRAMES - 1)) &&
                    (blk_q == BLK_W'(DS3_BLOCKS - 1)) &&
                    (bit_q == BIT_W'(INFO_BITS));
  assign e3_last  = (pos_q == POS_W'(E3_BITS - 1));
  assign last     = e3_i ? e3_last : ds3_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      blk_q <= '0;
      sf_q  <= '0;
      pos_q <= '0;
    end else if (last) begin
      bit_q <= '0;
      blk_q <= '0;
      sf_q  <= '0;
      pos_q <= '0;
    end else if (e3_i) begin
      pos_q <= pos_q + 1'b1;
    end else if (bit_q == BIT_W'(INFO_BITS)) begin
      bit_q <= '0;
      if (blk_q == BLK_W'(DS3_BLOCKS - 1)) begin
        blk_q <= '0;
        sf_q  <= sf_q + 1'b1;
      end else begin
        blk_q <= blk_q + 1'b1;
      end
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign start_o = (bit_q == '0) && (blk_q == '0) && (sf_q == '0) && (pos_q == '0);
  assign bit_o   = bit_q;
  assign blk_o   = blk_q;
  assign sf_o    = sf_q;
  assign pos_o   = pos_q;

endmodule

// File: rtl/maint_pattern_gen.sv
module maint_pattern_gen #(
  parameter int unsigned PAT_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic adv_i,
  output logic ais_bit_o,
  output logic idle_bit_o
);

  logic [PAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_q + 1'b1;
  end

  // phase counts payload bits only, so overhead gaps do not shift it
  assign ais_bit_o  = ~cnt_q[0];
  assign idle_bit_o = ~cnt_q[PAT_W-1];

endmodule

// File: rtl/ds3_parity_acc.sv
module ds3_parity_acc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic info_i,
  input  logic bit_i,
  output logic par_o
);

  logic acc_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= 1'b0;
      snap_q <= 1'b0;
    end else if (start_i) begin
      snap_q <= acc_q;
      acc_q  <= 1'b0;
    end else if (info_i) begin
      acc_q  <= acc_q ^ bit_i;
    end
  end

  assign par_o = snap_q;

endmodule

// File: rtl/ds3e3_maint_gen.sv
module ds3e3_maint_gen
  import tx_maint_pkg::*;
#(
  parameter int unsigned INFO_BITS = 84,
  parameter int unsigned E3_BITS   = 1536,
  parameter int unsigned FAS_LEN   = 10,
  parameter logic [FAS_LEN-1:0] FAS_WORD = 10'b1111010000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       e3_mode_i,
  input  logic       ais_i,
  input  logic       rai_i,
  input  logic       idle_i,
  input  logic [1:0] sn_sel_i,
  input  logic       data_i,
  input  logic       c_bit_i,
  input  logic       hdlc_bit_i,
  input  logic       feac_bit_i,
  output logic       tx_bit_o,
  output logic       frame_start_o
);

  localparam int unsigned BIT_W = $clog2(INFO_BITS + 1);
  localparam int unsigned BLK_W = $clog2(DS3_BLOCKS);
  localparam int unsigned SF_W  = $clog2(DS3_SUBFRAMES);
  localparam int unsigned POS_W = $clog2(E3_BITS);

  logic             start;
  logic [BIT_W-1:0] ctr_bit;
  logic [BLK_W-1:0] ctr_blk;
  logic [SF_W-1:0]  ctr_sf;
  logic [POS_W-1:0] ctr_pos;

  tx_cfg_t cfg_in, cfg_q, cfg_eff;
  logic    cur_e3, cur_ais;

  always_comb begin
    cfg_in.e3     = e3_mode_i;
    cfg_in.ais    = ais_i;
    cfg_in.rai    = rai_i;
    cfg_in.idle   = idle_i;
    cfg_in.sn_sel = sn_sel_i;
  end

  // controls take effect only on the first bit of a frame
  assign cfg_eff = start ? cfg_in : cfg_q;
  assign cur_e3  = cfg_eff.e3;
  assign cur_ais = cfg_eff.ais;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_eff;
  end

  ds3e3_frame_ctr #(
    .INFO_BITS (INFO_BITS),
    .E3_BITS   (E3_BITS)
  ) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .e3_i    (cur_e3),
    .start_o (start),
    .bit_o   (ctr_bit),
    .blk_o   (ctr_blk),
    .sf_o    (ctr_sf),
    .pos_o   (ctr_pos)
  );

  ds3_slot_e slot;
  logic      ds3_info;
  logic      pat_ais, pat_idle, par;
  logic      sn_bit, ds3_bit, e3_bit, bit_nxt;
  logic [FAS_LEN-1:0] fas_sh;

  always_comb begin
    if (ctr_bit != '0) begin
      slot = SLOT_INFO;
    end else begin
      unique case (ctr_blk)
        BLK_W'(0): begin
          if (ctr_sf < SF_W'(2))      slot = SLOT_X;
          else if (ctr_sf < SF_W'(4)) slot = SLOT_P;
          else                        slot = SLOT_M;
        end
        BLK_W'(1), BLK_W'(7): slot = SLOT_F1;
        BLK_W'(3), BLK_W'(5): slot = SLOT_F0;
        default:              slot = SLOT_C;
      endcase
    end
  end

  assign ds3_info = !cur_e3 && (slot == SLOT_INFO);

  maint_pattern_gen #(.PAT_W(2)) u_pat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .adv_i      (ds3_info),
    .ais_bit_o  (pat_ais),
    .idle_bit_o (pat_idle)
  );

  ds3_parity_acc u_par (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .info_i  (ds3_info),
    .bit_i   (bit_nxt),
    .par_o   (par)
  );

  always_comb begin
    unique case (slot)
      SLOT_INFO: ds3_bit = cur_ais ? pat_ais : (cfg_eff.idle ? pat_idle : data_i);
      SLOT_X:    ds3_bit = (cur_ais || cfg_eff.idle) ? 1'b1 : ~cfg_eff.rai;
      SLOT_P:    ds3_bit = par;
      SLOT_M:    ds3_bit = (ctr_sf == SF_W'(5));
      SLOT_F1:   ds3_bit = 1'b1;
      SLOT_F0:   ds3_bit = 1'b0;
      SLOT_C:    ds3_bit = cur_ais ? 1'b0 :
                           ((cfg_eff.idle && ctr_sf == SF_W'(2)) ? 1'b0 : c_bit_i);
      default:   ds3_bit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cfg_eff.sn_sel)
      SN_ONE:  sn_bit = 1'b1;
      SN_HDLC: sn_bit = hdlc_bit_i;
      SN_FEAC: sn_bit = feac_bit_i;
      default: sn_bit = 1'b0;
    endcase
  end

  assign fas_sh = FAS_WORD << ctr_pos;

  always_comb begin
    if (cur_ais)                              e3_bit = 1'b1;
    else if (ctr_pos < POS_W'(FAS_LEN))       e3_bit = fas_sh[FAS_LEN-1];
    else if (ctr_pos == POS_W'(FAS_LEN))      e3_bit = cfg_eff.rai;
    else if (ctr_pos == POS_W'(FAS_LEN + 1))  e3_bit = sn_bit;
    else                                      e3_bit = data_i;
  end

  assign bit_nxt = cur_e3 ? e3_bit : ds3_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_bit_o      <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      tx_bit_o      <= bit_nxt;
      frame_start_o <= start;
    end
  end

endmodule

// File: rtl/ds3e3_maint_gen_chk.sv
module ds3e3_maint_gen_chk
  import tx_maint_pkg::*;
#(
  parameter int unsigned INFO_BITS = 84,
  parameter int unsigned E3_BITS   = 1536,
  localparam int unsigned BIT_W   = $clog2(INFO_BITS + 1),
  localparam int unsigned BLK_W   = $clog2(DS3_BLOCKS),
  localparam int unsigned SF_W    = $clog2(DS3_SUBFRAMES),
  localparam int unsigned POS_W   = $clog2(E3_BITS),
  localparam int unsigned DS3_LEN = DS3_SUBFRAMES * DS3_BLOCKS * (INFO_BITS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_bit_o,
  input logic             frame_start_o,
  input logic             cur_e3,
  input logic             cur_ais,
  input logic             ctr_start,
  input logic [BIT_W-1:0] ctr_bit,
  input logic [BLK_W-1:0] ctr_blk,
  input logic [SF_W-1:0]  ctr_sf,
  input logic [POS_W-1:0] ctr_pos
);

  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_start_o) begin
      gap_q  <= 32'd1;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 32'd1;
    end
  end

  a_r1_frame_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && seen_q) |-> (gap_q == DS3_LEN || gap_q == E3_BITS));

  a_r1_f_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_e3 && ctr_bit == '0 && (ctr_blk == BLK_W'(1) || ctr_blk == BLK_W'(7))) |=> tx_bit_o);

  a_r1_m_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_e3 && ctr_bit == '0 && ctr_blk == '0 && ctr_sf == SF_W'(5)) |=> tx_bit_o);

  a_r4_ais_c_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_e3 && cur_ais && ctr_bit == '0 &&
     (ctr_blk == BLK_W'(2) || ctr_blk == BLK_W'(4) || ctr_blk == BLK_W'(6))) |=> !tx_bit_o);

  a_r9_e3_ais_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_e3 && cur_ais) |=> tx_bit_o);

  a_r7_fas_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_e3 && !cur_ais && ctr_pos < POS_W'(4)) |=> tx_bit_o);

  a_r11_start_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (frame_start_o == $past(ctr_start)));

endmodule

bind ds3e3_maint_gen ds3e3_maint_gen_chk #(
  .INFO_BITS (INFO_BITS),
  .E3_BITS   (E3_BITS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_bit_o      (tx_bit_o),
  .frame_start_o (frame_start_o),
  .cur_e3        (cur_e3),
  .cur_ais       (cur_ais),
  .ctr_start     (start),
  .ctr_bit       (ctr_bit),
  .ctr_blk       (ctr_blk),
  .ctr_sf        (ctr_sf),
  .ctr_pos       (ctr_pos)
);

// File: tb/ds3e3_maint_gen_test.sv
`timescale 1ns/1ps
module ds3e3_maint_gen_test;

  localparam int INFO  = 84;
  localparam int SUBF  = 7;
  localparam int BLKS  = 8;
  localparam int E3LEN = 1536;
  localparam logic [9:0] FAS = 10'b1111010000;
  localparam int NVEC = 10;
  // {e3, ais, rai, idle, sn_sel[1:0]}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000000, 6'b001000, 6'b010000, 6'b000100, 6'b011100,
    6'b100000, 6'b101001, 6'b100010, 6'b100111, 6'b110000
  };

  logic clk = 1'b0;
  logic rst_n;
  logic e3, ais, rai, idle;
  logic [1:0] sn;
  logic dat, cb, hd, fe;
  logic tx, fs;

  always #2 clk = ~clk;

  ds3e3_maint_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .e3_mode_i(e3), .ais_i(ais), .rai_i(rai),
    .idle_i(idle), .sn_sel_i(sn), .data_i(dat), .c_bit_i(cb),
    .hdlc_bit_i(hd), .feac_bit_i(fe), .tx_bit_o(tx), .frame_start_o(fs)
  );

  int nchk = 0, nfail = 0, frames_done = 0;
  int b_bit, b_blk, b_sf, b_pos, b_info;
  int o_bitn, o_blk, o_sf, o_pos;
  logic o_bit, o_fs, o_e3;
  logic acc, par;
  logic [5:0] m_cfg;
  bit open_frame;
  int f_err, f_bad;
  logic f_act, f_exp;
  string f_tag;
  logic [15:0] lfsr;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic act, input logic exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] c);
    if (c[5]) begin
      if (c[4] || c[2]) return "R9";
      if (c[1:0] != 2'b00 || c[3]) return "R8";
      return "R7";
    end
    if (c[4]) return c[2] ? "R6" : "R4";
    if (c[2]) return "R5";
    if (c[3]) return "R3";
    return "R1";
  endfunction

  function automatic logic exp_bit(input logic [5:0] c, input int sf, input int blk,
                                   input int bn, input int pos, input int info,
                                   input logic d, input logic cbit, input logic h,
                                   input logic f, input logic p);
    logic ea, er, ei;
    ea = c[4]; er = c[3]; ei = c[2];
    if (c[5]) begin
      if (ea) return 1'b1;
      if (pos < 10) return FAS[9-pos];
      if (pos == 10) return er;
      if (pos == 11) begin
        case (c[1:0])
          2'b00: return 1'b1;
          2'b01: return h;
          2'b10: return f;
          default: return 1'b0;
        endcase
      end
      return d;
    end
    if (bn != 0) begin
      if (ea) return (info % 2) == 0;
      if (ei) return ((info / 2) % 2) == 0;
      return d;
    end
    case (blk)
      0: begin
        if (sf < 2) return (ea || ei) ? 1'b1 : !er;
        if (sf < 4) return p;
        return sf == 5;
      end
      1, 7: return 1'b1;
      3, 5: return 1'b0;
      default: begin
        if (ea) return 1'b0;
        if (ei && sf == 2) return 1'b0;
        return cbit;
      end
    endcase
  endfunction

  task automatic model_clear();
    b_bit = 0; b_blk = 0; b_sf = 0; b_pos = 0; b_info = 0;
    acc = 1'b0; par = 1'b0; open_frame = 0; f_err = 0;
  endtask

  task automatic step();
    bit st;
    logic ex;
    @(negedge clk);
    o_bit = tx; o_fs = fs;
    st = (b_bit == 0 && b_blk == 0 && b_sf == 0 && b_pos == 0);
    if (st) begin
      if (open_frame) begin
        check(f_err == 0, f_tag, $sformatf("frame content, first bad bit %0d", f_bad), f_act, f_exp);
        frames_done++;
      end
      m_cfg = {e3, ais, rai, idle, sn};
      par = acc; acc = 1'b0;
      open_frame = 1; f_err = 0; b_info = 0;
      f_tag = tag_of(m_cfg);
    end
    o_e3 = m_cfg[5]; o_sf = b_sf; o_blk = b_blk; o_bitn = b_bit; o_pos = b_pos;
    ex = exp_bit(m_cfg, b_sf, b_blk, b_bit, b_pos, b_info, dat, cb, hd, fe, par);
    if (o_fs !== logic'(st) || o_bit !== ex) begin
      if (f_err == 0) begin
        f_bad = m_cfg[5] ? b_pos : b_sf * 680 + b_blk * 85 + b_bit;
        f_act = o_bit; f_exp = ex;
      end
      f_err++;
    end
    if (!m_cfg[5] && b_bit == 0 && b_blk == 0 && (b_sf == 2 || b_sf == 3))
      check(o_bit === par, "R2", "P bit", o_bit, par);
    if (!m_cfg[5] && b_bit != 0) begin
      acc = acc ^ o_bit;
      b_info++;
    end
    if (m_cfg[5]) begin
      b_pos = (b_pos == E3LEN - 1) ? 0 : b_pos + 1;
    end else if (b_bit == INFO) begin
      b_bit = 0;
      if (b_blk == BLKS - 1) begin
        b_blk = 0;
        b_sf = (b_sf == SUBF - 1) ? 0 : b_sf + 1;
      end else b_blk++;
    end else b_bit++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dat = lfsr[0]; cb = lfsr[3]; hd = lfsr[7]; fe = lfsr[11];
  endtask

  task automatic run_frames(input int n);
    int target;
    target = frames_done + n;
    while (frames_done < target) step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tx === 1'b0 && fs === 1'b0, "R11", "outputs low in reset", tx | fs, 1'b0);
    end
    model_clear();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R11 watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {e3, ais, rai, idle, sn} = 6'b000000;
    dat = 1'b0; cb = 1'b0; hd = 1'b0; fe = 1'b0;
    lfsr = 16'hace1;
    model_clear();
    repeat (2) @(negedge clk);
    check(tx === 1'b0 && fs === 1'b0, "R11", "reset state", tx | fs, 1'b0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      {e3, ais, rai, idle, sn} = VEC[v];
      run_frames(2);
    end

    // R10: mid-frame control change waits for the next frame
    {e3, ais, rai, idle, sn} = 6'b000000;
    run_frames(1);
    repeat (100) step();
    rai = 1'b1;
    do step(); while (!(o_sf == 1 && o_blk == 0 && o_bitn == 0));
    check(o_bit === 1'b1, "R10", "X bit after mid-frame RAI change", o_bit, 1'b1);
    do step(); while (!(o_fs && !o_e3));
    check(o_bit === 1'b0, "R3", "X bit with RAI in next frame", o_bit, 1'b0);

    // R10: mid-frame switch to E3 keeps current DS3 frame length
    repeat (200) step();
    e3 = 1'b1; rai = 1'b0;
    run_frames(2);

    // R11: reset in mid-frame restarts framing
    e3 = 1'b0;
    repeat (300) step();
    do_reset();
    step();
    check(o_fs === 1'b1, "R11", "frame mark on first bit after reset", o_fs, 1'b1);
    run_frames(1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule